// File: doc/BRIEF.md
# Partitioned Saturating Lane Adder

This block is a 64-bit adder/subtractor whose carry chain can be split into independent lanes: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes, or one 64-bit lane. A single operation therefore acts on every lane at once. Each lane can be treated as signed or unsigned. A lane can wrap on overflow, as plain two's-complement arithmetic does, or it can clamp to the nearest limit its width can represent. Clamping suits media work such as audio clipping or pixel saturation.

The result and a per-byte overflow mask are registered once, so they appear one clock after the operands. A bit of the mask is set for every byte that belongs to a lane that overflowed. Software can use the mask whether or not clamping is on.

Top module: `simd_sat_adder`

## Requirements
- R1: While `rst_ni` is low, `result_o` and `ovf_mask_o` are zero.
- R2: `lane_mode_i` selects the lane width: 2'b00 gives 8-bit, 2'b01 gives 16-bit, 2'b10 gives 32-bit and 2'b11 gives one 64-bit lane. Lane n covers result bits [w*n+w-1 : w*n]. With `sub_i`=0 and no clamping, each lane holds (a + b) mod 2^w, and no carry crosses into the next lane.
- R3: With `sub_i`=1, each lane holds (a - b) mod 2^w. The carry entering every lane is the subtract carry-in, not the carry out of the lane below.
- R4: With `signed_i`=1, a lane overflows when the effective operands share a sign and the lane result has the other sign. For subtraction this means the two original operands have different signs and the result sign differs from that of a.
- R5: With `signed_i`=0, an add lane overflows when it carries out of its top bit. A subtract lane overflows when a < b as unsigned values.
- R6: Bit k of `ovf_mask_o` refers to byte k, which is result bits [8k+7:8k]. The bit is 1 exactly when the lane containing byte k overflowed. This holds for any setting of `sat_i`.
- R7: With `sat_i`=0, an overflowing lane still holds the wrapped modulo result.
- R8: With `sat_i`=1 and `signed_i`=1, an overflowing lane holds the signed maximum (0x7F..FF) when a is non-negative. It holds the signed minimum (0x80..00) when a is negative.
- R9: With `sat_i`=1 and `signed_i`=0, an overflowing add lane holds all ones and an overflowing subtract lane holds zero.
- R10: Both outputs update only at the rising clock edge that samples the inputs. A change of input between edges does not reach the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 64 | First operand, packed lanes |
| b_i | input | 64 | Second operand, packed lanes |
| lane_mode_i | input | 2 | Lane width select (00: 8, 01: 16, 10: 32, 11: 64) |
| sub_i | input | 1 | 1 = a - b, 0 = a + b |
| signed_i | input | 1 | 1 = lanes are two's-complement signed |
| sat_i | input | 1 | 1 = clamp overflowing lanes |
| result_o | output | 64 | Registered lane results |
| ovf_mask_o | output | 8 | Registered per-byte overflow mask |

## Verification
The bench sweeps every lane width, operation, signedness and clamp setting over boundary operands: 0x80, 0x7F, all ones, zero, and values that sit just over a lane seam. It also uses pseudo-random operands and compares both outputs with an arithmetic reference model.

Each of the following faults produces a visible difference:
- A carry leaking across a lane seam corrupts the lane above by one.
- A seam carry-in that ignores subtraction leaves upper lanes off by one.
- Testing the unsigned carry instead of the sign rule, or the reverse, flags the wrong lanes.
- Clamping to the wrong limit shows up as 0x80 in place of 0x7F, or as all ones in place of zero on an unsigned borrow.
- A mask that marks only the top byte of a lane leaves the lower mask bits clear.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  typedef enum logic [1:0] {
    LANE_B8  = 2'b00,
    LANE_B16 = 2'b01,
    LANE_B32 = 2'b10,
    LANE_B64 = 2'b11
  } lane_mode_e;
endpackage

// File: rtl/simd_carry_chain.sv
module simd_carry_chain #(
  parameter int unsigned NUM_BYTES = 8,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned IDX_W     = $clog2(NUM_BYTES)
) (
  input  logic [NUM_BYTES*BYTE_W-1:0] a_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] bx_i,
  input  logic                        sub_i,
  input  logic [IDX_W-1:0]            lb_m1_i,
  output logic [NUM_BYTES*BYTE_W-1:0] sum_o,
  output logic [NUM_BYTES-1:0]        cout_o
);
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    logic            cin;
    logic [BYTE_W:0] part;
    if (g == 0) begin : g_first
      assign cin = sub_i;
    end else begin : g_rest
      // lane seam: restart with the subtract carry-in
      assign cin = ((IDX_W'(g) & lb_m1_i) == '0) ? sub_i : cout_o[g-1];
    end
    assign part = {1'b0, a_i[g*BYTE_W +: BYTE_W]} + {1'b0, bx_i[g*BYTE_W +: BYTE_W]}
                + (BYTE_W+1)'(cin);
    assign sum_o[g*BYTE_W +: BYTE_W] = part[BYTE_W-1:0];
    assign cout_o[g] = part[BYTE_W];
  end
endmodule

// File: rtl/simd_lane_flags.sv
module simd_lane_flags #(
  parameter int unsigned NUM_BYTES = 8,
  parameter int unsigned IDX_W     = $clog2(NUM_BYTES)
) (
  input  logic [NUM_BYTES-1:0] a_msb_i,
  input  logic [NUM_BYTES-1:0] bx_msb_i,
  input  logic [NUM_BYTES-1:0] sum_msb_i,
  input  logic [NUM_BYTES-1:0] cout_i,
  input  logic                 sub_i,
  input  logic                 signed_i,
  input  logic [IDX_W-1:0]     lb_m1_i,
  output logic [NUM_BYTES-1:0] byte_ovf_o,
  output logic [NUM_BYTES-1:0] byte_fill_o,
  output logic [NUM_BYTES-1:0] byte_top_o
);
  logic [NUM_BYTES-1:0] ovf_at, fill_at;

  // flags as if each byte were the top byte of its lane
  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_cand
    logic s_ovf, u_ovf;
    assign s_ovf      = (a_msb_i[k] == bx_msb_i[k]) && (sum_msb_i[k] != a_msb_i[k]);
    assign u_ovf      = cout_i[k] ^ sub_i;
    assign ovf_at[k]  = signed_i ? s_ovf : u_ovf;
    assign fill_at[k] = signed_i ? ~a_msb_i[k] : ~sub_i;
  end

  // spread the top byte's decision over the whole lane
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_spread
    logic [IDX_W-1:0] top_idx;
    assign top_idx        = IDX_W'(g) | lb_m1_i;
    assign byte_ovf_o[g]  = ovf_at[top_idx];
    assign byte_fill_o[g] = fill_at[top_idx];
    assign byte_top_o[g]  = (top_idx == IDX_W'(g));
  end
endmodule

// File: rtl/simd_sat_mux.sv
module simd_sat_mux #(
  parameter int unsigned NUM_BYTES = 8,
  parameter int unsigned BYTE_W    = 8
) (
  input  logic [NUM_BYTES*BYTE_W-1:0] sum_i,
  input  logic [NUM_BYTES-1:0]        byte_ovf_i,
  input  logic [NUM_BYTES-1:0]        byte_fill_i,
  input  logic [NUM_BYTES-1:0]        byte_top_i,
  input  logic                        signed_i,
  input  logic                        sat_i,
  output logic [NUM_BYTES*BYTE_W-1:0] res_o
);
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    logic [BYTE_W-1:0] clamp;
    always_comb begin
      clamp = {BYTE_W{byte_fill_i[g]}};
      // signed limit: the lane MSB is the inverse of the fill
      if (signed_i && byte_top_i[g]) clamp[BYTE_W-1] = ~byte_fill_i[g];
    end
    assign res_o[g*BYTE_W +: BYTE_W] = (sat_i && byte_ovf_i[g]) ? clamp
                                                                : sum_i[g*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder import simd_add_pkg::*; #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DATA_W-1:0]        a_i,
  input  logic [DATA_W-1:0]        b_i,
  input  logic [1:0]               lane_mode_i,
  input  logic                     sub_i,
  input  logic                     signed_i,
  input  logic                     sat_i,
  output logic [DATA_W-1:0]        result_o,
  output logic [DATA_W/BYTE_W-1:0] ovf_mask_o
);
  localparam int unsigned NUM_BYTES = DATA_W / BYTE_W;
  localparam int unsigned IDX_W     = $clog2(NUM_BYTES);

  logic [DATA_W-1:0]    bx, sum, res_d;
  logic [NUM_BYTES-1:0] cout, a_msb, bx_msb, sum_msb;
  logic [NUM_BYTES-1:0] byte_ovf, byte_fill, byte_top;
  logic [IDX_W-1:0]     lb_m1;

  assign bx = sub_i ? ~b_i : b_i;

  always_comb begin
    unique case (lane_mode_e'(lane_mode_i))
      LANE_B8:  lb_m1 = '0;
      LANE_B16: lb_m1 = IDX_W'(1);
      LANE_B32: lb_m1 = IDX_W'(3);
      default:  lb_m1 = IDX_W'(NUM_BYTES - 1);
    endcase
  end

  simd_carry_chain #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_chain (
    .a_i     (a_i),
    .bx_i    (bx),
    .sub_i   (sub_i),
    .lb_m1_i (lb_m1),
    .sum_o   (sum),
    .cout_o  (cout)
  );

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_msb
    assign a_msb[g]   = a_i[g*BYTE_W + BYTE_W - 1];
    assign bx_msb[g]  = bx[g*BYTE_W + BYTE_W - 1];
    assign sum_msb[g] = sum[g*BYTE_W + BYTE_W - 1];
  end

  simd_lane_flags #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_flags (
    .a_msb_i     (a_msb),
    .bx_msb_i    (bx_msb),
    .sum_msb_i   (sum_msb),
    .cout_i      (cout),
    .sub_i       (sub_i),
    .signed_i    (signed_i),
    .lb_m1_i     (lb_m1),
    .byte_ovf_o  (byte_ovf),
    .byte_fill_o (byte_fill),
    .byte_top_o  (byte_top)
  );

  simd_sat_mux #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_sat (
    .sum_i       (sum),
    .byte_ovf_i  (byte_ovf),
    .byte_fill_i (byte_fill),
    .byte_top_i  (byte_top),
    .signed_i    (signed_i),
    .sat_i       (sat_i),
    .res_o       (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o   <= '0;
      ovf_mask_o <= '0;
    end else begin
      result_o   <= res_d;
      ovf_mask_o <= byte_ovf;
    end
  end
endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [63:0] a_i,
  input logic [63:0] b_i,
  input logic [1:0]  lane_mode_i,
  input logic        sub_i,
  input logic        signed_i,
  input logic        sat_i,
  input logic [63:0] result_o,
  input logic [7:0]  ovf_mask_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R2 / R3: a single wide lane without clamping is plain modulo arithmetic
  assert_wide_lane_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(lane_mode_i) == 2'b11 && !$past(sat_i) |->
      result_o == ($past(sub_i) ? $past(a_i) - $past(b_i) : $past(a_i) + $past(b_i)));

  assert_mask_lane_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(lane_mode_i) == 2'b01 |->
      ovf_mask_o[0] == ovf_mask_o[1] && ovf_mask_o[2] == ovf_mask_o[3] &&
      ovf_mask_o[4] == ovf_mask_o[5] && ovf_mask_o[6] == ovf_mask_o[7]);

  assert_uadd_clamp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(sat_i) && !$past(signed_i) && !$past(sub_i) &&
    $past(lane_mode_i) == 2'b00 && ovf_mask_o[0] |-> result_o[7:0] == 8'hFF);

  assert_usub_clamp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(sat_i) && !$past(signed_i) && $past(sub_i) &&
    $past(lane_mode_i) == 2'b00 && ovf_mask_o[0] |-> result_o[7:0] == 8'h00);

  assert_signed_clamp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(sat_i) && $past(signed_i) && $past(lane_mode_i) == 2'b00 &&
    ovf_mask_o[0] |-> result_o[7:0] == ($past(a_i[7]) ? 8'h80 : 8'h7F));
endmodule

bind simd_sat_adder simd_sat_adder_chk u_chk (.*);

// File: tb/sim_simd_sat_adder.sv
module sim_simd_sat_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] a = '0, b = '0;
  logic [1:0]  mode = 2'b00;
  logic        sub = 1'b0, sgn = 1'b0, sat = 1'b0;
  logic [63:0] result;
  logic [7:0]  mask;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;
  logic [63:0] pat [8];
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;

  simd_sat_adder u0 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .lane_mode_i(mode),
    .sub_i(sub), .signed_i(sgn), .sat_i(sat), .result_o(result), .ovf_mask_o(mask)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // arithmetic reference, lane by lane
  task automatic model(input logic [63:0] x, input logic [63:0] y, input logic [1:0] m,
                       input logic s, input logic sg, input logic st,
                       output logic [63:0] res, output logic [7:0] msk, output bit any);
    int w = (m == 2'b11) ? 64 : (8 << m);
    logic [64:0] lm = (65'd1 << w) - 65'd1;
    res = '0; msk = '0; any = 1'b0;
    for (int l = 0; l < 64 / w; l++) begin
      logic [64:0] ua, ub, full, raw, val;
      bit ov, sa, sb, sr;
      ua = ({1'b0, x} >> (l * w)) & lm;
      ub = ({1'b0, y} >> (l * w)) & lm;
      full = s ? ua - ub : ua + ub;
      raw = full & lm;
      sa = ua[w-1]; sb = ub[w-1]; sr = raw[w-1];
      if (sg) ov = s ? (sa != sb && sr != sa) : (sa == sb && sr != sa);
      else    ov = s ? (ua < ub) : full[w];
      val = raw;
      if (ov && st) begin
        if (sg) val = sa ? (65'd1 << (w - 1)) : (lm >> 1);
        else    val = s ? 65'd0 : lm;
      end
      res |= val[63:0] << (l * w);
      if (ov) begin
        any = 1'b1;
        for (int k = 0; k < w / 8; k++) msk[l * (w / 8) + k] = 1'b1;
      end
    end
  endtask

  task automatic run_one(logic [63:0] x, logic [63:0] y, logic [1:0] m,
                         logic s, logic sg, logic st);
    logic [63:0] er; logic [7:0] em; bit any;
    string rt;
    model(x, y, m, s, sg, st, er, em, any);
    @(negedge clk);
    a = x; b = y; mode = m; sub = s; sgn = sg; sat = st;
    @(negedge clk);
    if (any && st) rt = sg ? "R8" : "R9";
    else if (any)  rt = "R7";
    else           rt = s ? "R3" : "R2";
    check(rt, result, er);
    check(sg ? "R4,R6" : "R5,R6", {56'h0, mask}, {56'h0, em});
  endtask

  function automatic logic [63:0] next_rand();
    rng ^= rng << 13; rng ^= rng >> 7; rng ^= rng << 17;
    return rng;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] er; logic [7:0] em; bit any;
    pat[0] = 64'h0; pat[1] = '1; pat[2] = 64'h8080_8080_8080_8080;
    pat[3] = 64'h7F7F_7F7F_7F7F_7F7F; pat[4] = 64'h0101_0101_0101_0101;
    pat[5] = 64'hFF00_FF00_FF00_FF00; pat[6] = 64'h8000_0000_7FFF_FFFF;
    pat[7] = 64'h00FF_7F80_FFFF_0001;
    a = 64'hFFFF_FFFF_FFFF_FFFF; b = 64'h1; sat = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", result, 64'h0);
    check("R1", {56'h0, mask}, 64'h0);
    rst_n = 1'b1;

    for (int cfg = 0; cfg < 16; cfg++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_one(pat[i], pat[j], cfg[3:2], cfg[1], cfg[0], cfg[2] ^ cfg[3] ^ cfg[1] ^ cfg[0] ? 1'b1 : 1'b0);
    for (int cfg = 0; cfg < 32; cfg++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_one(pat[i], pat[j], cfg[4:3], cfg[2], cfg[1], cfg[0]);
    for (int n = 0; n < 300; n++)
      for (int cfg = 0; cfg < 32; cfg++)
        run_one(next_rand(), next_rand(), cfg[4:3], cfg[2], cfg[1], cfg[0]);

    // R10: an input change between edges does not reach the outputs
    run_one(64'h0000_0000_0000_0010, 64'h0000_0000_0000_0020, 2'b00, 1'b0, 1'b0, 1'b0);
    a = 64'h0000_0000_0000_0005;
    #1 check("R10", result, 64'h0000_0000_0000_0030);
    model(a, b, mode, sub, sgn, sat, er, em, any);
    @(negedge clk);
    check("R10", result, er);

    // R1: reset mid-run clears nonzero outputs
    run_one(64'hFF, 64'h01, 2'b00, 1'b0, 1'b0, 1'b0);
    #1 rst_n = 1'b0;
    #1 check("R1", result, 64'h0);
    check("R1", {56'h0, mask}, 64'h0);
    @(negedge clk) rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule